// File: doc/BRIEF.md
# Append-Only Element Log Controller

This block keeps small data elements in a reserved range of flash words that is used as an append-only log. Each element is named by an 8-bit number and carries one to four 16-bit words. An update never rewrites a stored record: a write walks the log from its start to find the first blank header position, then programs a new record there. A read walks the whole log, remembers the last record whose number matches, and returns that copy's data.

The log is split into fixed-size pages. A record never straddles a page boundary. When a record does not fit in what is left of the current page, the controller programs a page-end marker and places the record at word 0 of the next page. If there is no next page, the write is refused and the flash is left untouched. The flash port has a one-cycle read latency. A program pulse only takes effect on a blank word.

Top module: `record_log_ctrl`

## Requirements
- R1: A stored record is a header word followed by its data words, with data word 0 first. The header holds the element number in bits 7:0, the length minus one in bits 9:8, and zero in bits 15:10. A blank flash word reads 16'hFFFF.
- R2: A write programs its record starting at the first position where a header is expected and the word is blank. It does this even when a record with the same number already exists. No word that is not blank is ever programmed.
- R3: When a record does not fit in the rest of its page, the controller first programs the marker word 16'h0000 at the end position. The record then begins at word 0 of the next page.
- R4: When no later page exists for a record that does not fit, or the log is at the end of the region, the write responds with status FULL (2) and programs nothing.
- R5: A read of a stored element responds with status OK (0). It returns the data of the last matching record, with word k in rsp_data bits 16k+15:16k, unused words zero, and rsp_len set to the length minus one. A write that succeeds also responds with OK.
- R6: A read of an element that is absent responds with status NOT_FOUND (1) and all-zero data.
- R7: A command with element number 0 responds with status BAD_ID (3) and does not access the flash.
- R8: A read command never programs the flash.
- R9: Each accepted command produces exactly one single-cycle rsp_valid pulse. cmd_ready is high only while the controller is idle.
- R10: The scan follows a marker to word 0 of the next page, so records on later pages are found. The scan ends at a blank header or at the end of the region.
- R11: After reset, cmd_ready is 1, rsp_valid is 0 and no flash access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when cmd_ready is high |
| cmd_ready | output | 1 | Controller idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_id | input | 8 | Element number |
| cmd_len | input | 2 | Length minus one (writes) |
| cmd_data | input | 64 | Write data, word k at bits 16k+15:16k |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 OK, 1 NOT_FOUND, 2 FULL, 3 BAD_ID |
| rsp_len | output | 2 | Length minus one of the returned or written record |
| rsp_data | output | 64 | Read data, zero when no data is returned |
| fl_rd_en | output | 1 | Flash read request, data is valid next cycle |
| fl_wr_en | output | 1 | Flash program pulse |
| fl_addr | output | 6 | Flash word address within the log region |
| fl_wdata | output | 16 | Word to program |
| fl_rdata | input | 16 | Flash read data |

## Verification
The checker watches the following on every cycle:
- reads never issue a program pulse;
- refused writes and element-0 commands never program;
- read and program requests never coincide;
- a not-found response carries zero data;
- the response is a single-cycle pulse while the controller is busy.

Only the bench scenarios can show the behaviours that depend on log contents. These are where each record lands, the marker placement at page ends, the choice of the newest duplicate, and the exact point at which the log reports full. The bench covers them by comparing the flash image and every response with a behavioural log model.

// File: rtl/rls_pkg.sv
// Shared types and header helpers for the element log controller.
// Assumes 16-bit flash words and 8-bit element numbers.
package rls_pkg;
    localparam int WORD_W = 16;
    localparam int ID_W   = 8;
    localparam logic [WORD_W-1:0] BLANK_WORD  = 16'hFFFF;
    localparam logic [WORD_W-1:0] MARKER_WORD = 16'h0000;

    typedef enum logic [1:0] {
        RS_OK       = 2'd0,
        RS_NOTFOUND = 2'd1,
        RS_FULL     = 2'd2,
        RS_BADID    = 2'd3
    } rls_status_e;

    // Build a header word: spare bits zero, length code, element number.
    function automatic logic [WORD_W-1:0] make_hdr(input logic [ID_W-1:0] id,
                                                    input logic [1:0] lc);
        return {6'b000000, lc, id};
    endfunction
endpackage

// File: rtl/rls_hdr_decode.sv
// Classifies a word read where a header is expected.
// Assumes blank words read all ones and the marker carries element 0.
module rls_hdr_decode
    import rls_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              is_blank,
    output logic              is_marker,
    output logic [ID_W-1:0]   id,
    output logic [1:0]        lc
);
    // Split the word into its fields and flag the special cases.
    always_comb begin
        is_blank  = (word == BLANK_WORD);
        is_marker = !is_blank && (word[ID_W-1:0] == '0);
        id        = word[ID_W-1:0];
        lc        = word[ID_W+1:ID_W];
    end
endmodule

// File: rtl/rls_space_plan.sv
// Decides where a record of a given length lands relative to the log end.
// Assumes PAGE_WORDS and NUM_PAGES are powers of two and PAGE_WORDS >= 8.
module rls_space_plan #(
    parameter int PAGE_WORDS = 16,
    parameter int NUM_PAGES  = 4,
    localparam int TOTAL     = PAGE_WORDS * NUM_PAGES,
    localparam int PTR_W     = $clog2(TOTAL) + 1,
    localparam int PG_BITS   = $clog2(PAGE_WORDS)
) (
    input  logic [PTR_W-1:0] end_ptr,
    input  logic [1:0]       lc,
    output logic             need_marker,
    output logic             full,
    output logic [PTR_W-1:0] rec_base,
    output logic [PTR_W-1:0] next_page
);
    logic [PG_BITS:0]       off_sum;
    logic [PTR_W-PG_BITS-1:0] page;
    logic                   at_end, fits, last;

    // Compute fit in the current page and the next page start.
    always_comb begin
        page      = end_ptr[PTR_W-1:PG_BITS];
        off_sum   = {1'b0, end_ptr[PG_BITS-1:0]} + (PG_BITS+1)'(lc) + (PG_BITS+1)'(2);
        at_end    = (end_ptr >= PTR_W'(TOTAL));
        fits      = !at_end && (off_sum <= (PG_BITS+1)'(PAGE_WORDS));
        last      = (page == (PTR_W-PG_BITS)'(NUM_PAGES-1));
        next_page = {page + 1'b1, {PG_BITS{1'b0}}};
        full        = at_end || (!fits && last);
        need_marker = !at_end && !fits && !last;
        rec_base    = fits ? end_ptr : next_page;
    end
endmodule

// File: rtl/rls_read_buf.sv
// Collects up to four data words of a fetched record into lanes.
// Assumes clr and load never coincide.
module rls_read_buf
    import rls_pkg::*;
#(
    parameter int LANES = 4,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    load,
    input  logic [IDX_W-1:0]        idx,
    input  logic [WORD_W-1:0]       word,
    output logic [LANES*WORD_W-1:0] data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WORD_W-1:0] lane_q;
        // Hold one data word, cleared at the start of each command.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                        lane_q <= '0;
            else if (load && idx == IDX_W'(g))        lane_q <= word;
        end
        assign data[g*WORD_W +: WORD_W] = lane_q;
    end
endmodule

// File: rtl/record_log_ctrl.sv
// Append-only element log controller: writes append records after the last
// one, reads scan the whole log and return the newest matching copy.
// Assumes a flash port with one-cycle read latency that only programs blank
// words, and that the log region holds only records written by this block.
module record_log_ctrl
    import rls_pkg::*;
#(
    parameter int PAGE_WORDS = 16,
    parameter int NUM_PAGES  = 4,
    localparam int TOTAL     = PAGE_WORDS * NUM_PAGES,
    localparam int FL_AW     = $clog2(TOTAL),
    localparam int PTR_W     = FL_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic [1:0]        cmd_len,
    input  logic [63:0]       cmd_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [1:0]        rsp_len,
    output logic [63:0]       rsp_data,
    output logic              fl_rd_en,
    output logic              fl_wr_en,
    output logic [FL_AW-1:0]  fl_addr,
    output logic [WORD_W-1:0] fl_wdata,
    input  logic [WORD_W-1:0] fl_rdata
);
    typedef enum logic [2:0] {
        S_IDLE, S_RD_HDR, S_WAIT_HDR, S_MARK, S_PROG, S_FETCH, S_WAIT_DATA, S_RESP
    } state_e;

    state_e            state;
    logic              op_wr;
    logic [ID_W-1:0]   id_q;
    logic [1:0]        lc_q;
    logic [63:0]       data_q;
    logic [PTR_W-1:0]  ptr;
    logic              found;
    logic [PTR_W-1:0]  hit_addr;
    logic [1:0]        hit_lc;
    logic [2:0]        cnt;
    rls_status_e       status_q;

    logic              h_blank, h_marker;
    logic [ID_W-1:0]   h_id;
    logic [1:0]        h_lc;
    logic              sp_marker, sp_full;
    logic [PTR_W-1:0]  sp_base, sp_next;
    logic              at_end, log_end, accept;
    logic              buf_clr, buf_load;

    rls_hdr_decode u_dec (
        .word(fl_rdata), .is_blank(h_blank), .is_marker(h_marker), .id(h_id), .lc(h_lc)
    );

    rls_space_plan #(.PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)) u_plan (
        .end_ptr(ptr), .lc(lc_q), .need_marker(sp_marker), .full(sp_full),
        .rec_base(sp_base), .next_page(sp_next)
    );

    rls_read_buf #(.LANES(4)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .load(buf_load),
        .idx(cnt[1:0]), .word(fl_rdata), .data(rsp_data)
    );

    // Decode acceptance and the end-of-log condition.
    always_comb begin
        accept   = cmd_valid && (state == S_IDLE);
        at_end   = (ptr >= PTR_W'(TOTAL));
        log_end  = ((state == S_RD_HDR) && at_end) || ((state == S_WAIT_HDR) && h_blank);
        buf_clr  = accept;
        buf_load = (state == S_WAIT_DATA);
    end

    // Drive the flash port from the current state.
    always_comb begin
        fl_rd_en = 1'b0;
        fl_wr_en = 1'b0;
        fl_addr  = ptr[FL_AW-1:0];
        fl_wdata = BLANK_WORD;
        case (state)
            S_RD_HDR: fl_rd_en = !at_end;
            S_MARK: begin
                fl_wr_en = 1'b1;
                fl_wdata = MARKER_WORD;
            end
            S_PROG: begin
                fl_wr_en = 1'b1;
                fl_addr  = FL_AW'(ptr + PTR_W'(cnt));
                fl_wdata = (cnt == 3'd0) ? make_hdr(id_q, lc_q)
                                         : data_q[16*(cnt-3'd1) +: 16];
            end
            S_FETCH: begin
                fl_rd_en = 1'b1;
                fl_addr  = FL_AW'(hit_addr + PTR_W'(1) + PTR_W'(cnt));
            end
            default: ;
        endcase
    end

    // Sequence the scan, program and fetch phases of each command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_wr    <= 1'b0;
            id_q     <= '0;
            lc_q     <= '0;
            data_q   <= '0;
            ptr      <= '0;
            found    <= 1'b0;
            hit_addr <= '0;
            hit_lc   <= '0;
            cnt      <= '0;
            status_q <= RS_OK;
        end else begin
            case (state)
                S_IDLE: if (accept) begin
                    op_wr  <= cmd_write;
                    id_q   <= cmd_id;
                    lc_q   <= cmd_len;
                    data_q <= cmd_data;
                    ptr    <= '0;
                    found  <= 1'b0;
                    hit_lc <= '0;
                    cnt    <= '0;
                    if (cmd_id == '0) begin
                        status_q <= RS_BADID;
                        state    <= S_RESP;
                    end else begin
                        state <= S_RD_HDR;
                    end
                end
                S_RD_HDR, S_WAIT_HDR: begin
                    if (log_end) begin
                        cnt <= '0;
                        if (op_wr) begin
                            if (sp_full) begin
                                status_q <= RS_FULL;
                                state    <= S_RESP;
                            end else if (sp_marker) begin
                                state <= S_MARK;
                            end else begin
                                state <= S_PROG;
                            end
                        end else if (found) begin
                            state <= S_FETCH;
                        end else begin
                            status_q <= RS_NOTFOUND;
                            state    <= S_RESP;
                        end
                    end else if (state == S_RD_HDR) begin
                        state <= S_WAIT_HDR;
                    end else begin
                        if (h_marker) begin
                            ptr <= sp_next;
                        end else begin
                            if (h_id == id_q) begin
                                found    <= 1'b1;
                                hit_addr <= ptr;
                                hit_lc   <= h_lc;
                            end
                            ptr <= ptr + PTR_W'(h_lc) + PTR_W'(2);
                        end
                        state <= S_RD_HDR;
                    end
                end
                S_MARK: begin
                    ptr   <= sp_base;
                    state <= S_PROG;
                end
                S_PROG: begin
                    if (cnt == {1'b0, lc_q} + 3'd1) begin
                        status_q <= RS_OK;
                        state    <= S_RESP;
                    end else begin
                        cnt <= cnt + 3'd1;
                    end
                end
                S_FETCH: state <= S_WAIT_DATA;
                S_WAIT_DATA: begin
                    if (cnt[1:0] == hit_lc) begin
                        status_q <= RS_OK;
                        state    <= S_RESP;
                    end else begin
                        cnt   <= cnt + 3'd1;
                        state <= S_FETCH;
                    end
                end
                S_RESP: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Present the response fields.
    always_comb begin
        cmd_ready  = (state == S_IDLE);
        rsp_valid  = (state == S_RESP);
        rsp_status = status_q;
        rsp_len    = op_wr ? lc_q : hit_lc;
    end
endmodule

// File: rtl/rls_checker.sv
// Cycle-level properties of the element log controller, bound to the top.
// Assumes the port encodings listed in the brief.
module rls_checker #(
    parameter int FL_AW = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_write,
    input logic             rsp_valid,
    input logic [1:0]       rsp_status,
    input logic [63:0]      rsp_data,
    input logic             fl_rd_en,
    input logic             fl_wr_en,
    input logic [FL_AW-1:0] fl_addr
);
    logic op_rd, progged, accessed;

    // Track the kind of command in flight and whether it touched the flash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_rd    <= 1'b0;
            progged  <= 1'b0;
            accessed <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            op_rd    <= !cmd_write;
            progged  <= 1'b0;
            accessed <= 1'b0;
        end else begin
            if (rsp_valid) op_rd <= 1'b0;
            if (fl_wr_en) progged <= 1'b1;
            if (fl_wr_en || fl_rd_en) accessed <= 1'b1;
        end
    end

    a_r8_read_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
        op_rd |-> !fl_wr_en);
    a_r4_full_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd2) |-> !progged);
    a_r7_badid_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd3) |-> !accessed);
    a_r6_notfound_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd1) |-> (rsp_data == '0));
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r9_busy_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);
    a_r2_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_rd_en && fl_wr_en));
endmodule

bind record_log_ctrl rls_checker #(.FL_AW(FL_AW)) u_rls_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_data(rsp_data), .fl_rd_en(fl_rd_en), .fl_wr_en(fl_wr_en), .fl_addr(fl_addr)
);

// File: tb/record_log_ctrl_bench.sv
module record_log_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW    = 16;
    localparam int NP    = 4;
    localparam int TOTAL = PW * NP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [7:0]  cmd_id = '0;
    logic [1:0]  cmd_len = '0;
    logic [63:0] cmd_data = '0;
    logic        cmd_ready, rsp_valid, fl_rd_en, fl_wr_en;
    logic [1:0]  rsp_status, rsp_len;
    logic [63:0] rsp_data;
    logic [5:0]  fl_addr;
    logic [15:0] fl_wdata, fl_rdata;

    int n_checks = 0, n_fail = 0;
    bit hung = 0;

    logic [15:0] fmem [TOTAL];
    logic [15:0] snap [TOTAL];

    // Behavioural log model
    int          m_ptr = 0;
    logic [63:0] m_data [int];
    int          m_lc   [int];
    bit          m_rdop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    record_log_ctrl #(.PAGE_WORDS(PW), .NUM_PAGES(NP)) u_record_log_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_id(cmd_id), .cmd_len(cmd_len), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_len(rsp_len),
        .rsp_data(rsp_data), .fl_rd_en(fl_rd_en), .fl_wr_en(fl_wr_en),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
    );

    // Flash model: one-cycle read latency, programs only blank words.
    initial for (int i = 0; i < TOTAL; i++) fmem[i] = 16'hFFFF;
    always @(posedge clk) begin
        if (fl_rd_en) fl_rdata <= fmem[fl_addr];
        if (fl_wr_en && fmem[fl_addr] == 16'hFFFF) fmem[fl_addr] <= fl_wdata;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock monitor of flash programming against model rules.
    always @(negedge clk) begin
        if (rst_n && fl_wr_en) begin
            check("R2 program target blank", {48'd0, fmem[fl_addr]}, 64'hFFFF);
            check("R8 no program during read", {63'd0, m_rdop}, 64'd0);
        end
    end

    task automatic issue(input bit wr, input logic [7:0] id, input logic [1:0] lc,
                         input logic [63:0] d);
        int t = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_id = id; cmd_len = lc; cmd_data = d;
        m_rdop = !wr;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!rsp_valid && t < 2000) begin
            check("R9 busy while pending", {63'd0, cmd_ready}, 64'd0);
            @(negedge clk);
            t++;
        end
        if (!rsp_valid) begin
            hung = 1; n_checks++; n_fail++;
            $display("FAIL R9 watchdog actual=no response expected=response");
        end
        m_rdop = 0;
    endtask

    task automatic do_write(input logic [7:0] id, input logic [1:0] lc, input logic [63:0] d);
        int need = lc + 2;
        int mark = -1;
        int base;
        logic [1:0] exp_st;
        for (int i = 0; i < TOTAL; i++) snap[i] = fmem[i];
        base = m_ptr;
        if (id == 0) exp_st = 2'd3;
        else if (m_ptr >= TOTAL) exp_st = 2'd2;
        else if ((m_ptr % PW) + need > PW) begin
            if (m_ptr / PW == NP - 1) exp_st = 2'd2;
            else begin
                exp_st = 2'd0; mark = m_ptr; base = (m_ptr / PW + 1) * PW;
            end
        end else exp_st = 2'd0;
        issue(1'b1, id, lc, d);
        if (hung) return;
        check("R5/R4/R7 write status", {62'd0, rsp_status}, {62'd0, exp_st});
        @(negedge clk);
        check("R9 single pulse", {63'd0, rsp_valid}, 64'd0);
        if (exp_st == 2'd0) begin
            if (mark >= 0) check("R3 marker word", {48'd0, fmem[mark]}, 64'd0);
            check("R1 R2 header placement", {48'd0, fmem[base]}, {48'd0, 6'd0, lc, id});
            for (int k = 0; k <= lc; k++)
                check("R1 data word", {48'd0, fmem[base+1+k]}, {48'd0, d[16*k +: 16]});
            m_ptr = base + need;
            m_data[id] = d;
            m_lc[id] = lc;
        end else begin
            int diff = 0;
            for (int i = 0; i < TOTAL; i++) if (fmem[i] !== snap[i]) diff++;
            check(exp_st == 2'd3 ? "R7 flash unchanged" : "R4 flash unchanged",
                  diff, 0);
        end
    endtask

    task automatic do_read(input logic [7:0] id);
        logic [63:0] exp_d = '0;
        logic [1:0]  exp_st;
        if (id == 0) exp_st = 2'd3;
        else if (m_lc.exists(id)) begin
            exp_st = 2'd0;
            for (int k = 0; k <= m_lc[id]; k++) exp_d[16*k +: 16] = m_data[id][16*k +: 16];
        end else exp_st = 2'd1;
        issue(1'b0, id, 2'd0, '0);
        if (hung) return;
        check("R5/R6/R7 read status", {62'd0, rsp_status}, {62'd0, exp_st});
        check("R5 R6 R10 read data", rsp_data, exp_d);
        if (exp_st == 2'd0)
            check("R5 read length", {62'd0, rsp_len}, {62'd0, 2'(m_lc[id])});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 ready after reset", {63'd0, cmd_ready}, 64'd1);
        check("R11 no response in reset", {63'd0, rsp_valid}, 64'd0);
        check("R11 no flash access", {62'd0, fl_rd_en, fl_wr_en}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 ready after release", {63'd0, cmd_ready}, 64'd1);

        do_read(8'd5);                                   // R6 empty log
        if (!hung) do_write(8'd5, 2'd1, 64'h0000_0000_BEEF_1234);
        if (!hung) do_write(8'd7, 2'd3, 64'h4444_3333_2222_1111);
        if (!hung) do_write(8'd5, 2'd0, 64'h0000_0000_0000_00A5); // R2 duplicate
        if (!hung) do_read(8'd5);                        // R5 newest copy
        if (!hung) do_read(8'd7);
        if (!hung) do_read(8'd9);                        // R6
        if (!hung) do_write(8'd0, 2'd2, 64'h1);          // R7
        if (!hung) do_read(8'd0);                        // R7
        if (!hung) do_write(8'd255, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF); // R1 id 255
        if (!hung) do_read(8'd255);
        // Fill the region: R3 markers, R10 page crossing, R4 full.
        for (int i = 0; i < 16 && !hung; i++)
            do_write(8'(20 + i), 2'd3, {4{8'(i), 8'h5A}});
        if (!hung) do_write(8'd40, 2'd0, 64'h77);        // R4 short record
        if (!hung) do_read(8'd7);                        // R10 scan to region end
        if (!hung) do_read(8'd30);
        if (!hung) do_read(8'd5);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule